// File: doc/BRIEF.md
# Double-Buffered Energy Histogrammer

This block accumulates the energy spectrum of one detector channel into a histogram of 2048 bins, each a saturating 32-bit counter. Two identical pages of bin storage alternate roles: one collects incoming energies, and the other holds the result of the previous measurement period so a host can read it at leisure. The histogram therefore has no dead time during readout. A seconds tick paces the measurement period. When the programmed number of seconds has elapsed, the pages trade roles, provided the outgoing readout page has been zeroed.

Each energy is mapped to a bin by subtracting a programmable offset and then shifting right by a programmable amount. Values outside the covered window fold into the lowest or the highest bin. Zeroing of a page is a sweep of one bin per clock. In automatic mode the block runs that sweep itself at the end of each period. While the sweep runs, the current page keeps counting, and the roles trade when the sweep completes. In user mode the host starts the sweep with a clear command. If the host has not cleared by the end of a period, the block either keeps accumulating into the same page or halts until the clear has been done, as the stop-mode setting selects. For the readout page the block also reports the lowest and highest occupied bins and whether any event landed there.

Top module: `energy_histogrammer`

## Requirements
- R1: An accepted energy E with E >= cfg_emin increments bin ((E - cfg_emin) >> cfg_shift) of the working page when that value is at most 2047.
- R2: An energy below cfg_emin counts in bin 0, and an energy whose shifted offset exceeds 2047 counts in bin 2047.
- R3: A bin counter that holds its maximum value (all ones) keeps that value when another event hits it.
- R4: rd_data returns the readout-page content of bin rd_addr one clock after rd_addr is sampled. page_sel gives the index (0 or 1) of the working page and is 0 after reset.
- R5: rec_time counts seconds ticks from 0. On the tick that brings it to cfg_meas_time, rec_time returns to 0 and meas_count increases by one.
- R6: With cfg_clr_mode = 0, a period end starts a sweep of the readout page. The working page keeps counting during the sweep, and page_sel toggles only when the sweep has completed.
- R7: With cfg_clr_mode = 1, a clr_cmd pulse zeroes every bin of the readout page, then sets clr_done and drops not_empty. With cfg_clr_mode = 0, clr_cmd has no effect.
- R8: With cfg_clr_mode = 1, a period end swaps the pages at once if clr_done is 1. If clr_done is 0 and cfg_hist_mode = 0, the pages stay as they are and counting continues into the same page.
- R9: With cfg_clr_mode = 1 and cfg_hist_mode = 1, a period end with clr_done = 0 raises halted. Energies are then dropped until the next clear sweep completes, which swaps the pages and lowers halted.
- R10: After a swap, first_bin and last_bin give the lowest and highest bins hit on the new readout page during its working time, and not_empty is 1 only if at least one event was counted there.
- R11: An event and a host read in the same cycle both take effect, because they use different pages.
- R12: After reset the block zeroes both pages over 2048 cycles and ignores energies meanwhile. When that sweep ends, clr_done is 1 and counting starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Energy strobe |
| evt_energy | input | 20 | Energy value |
| sec_tick | input | 1 | One-second pulse |
| cfg_emin | input | 20 | Offset subtracted before binning |
| cfg_shift | input | 4 | Right shift applied after the offset |
| cfg_meas_time | input | 32 | Period length in seconds |
| cfg_clr_mode | input | 1 | 0 = block clears, 1 = user clears |
| cfg_hist_mode | input | 1 | 1 = halt if the user has not cleared in time |
| clr_cmd | input | 1 | User clear pulse |
| rd_addr | input | 11 | Host read bin address |
| rd_data | output | 32 | Readout-page bin content |
| page_sel | output | 1 | Index of the working page |
| clr_done | output | 1 | Readout page is zeroed |
| halted | output | 1 | Accumulation stopped |
| rec_time | output | 32 | Seconds within the current period |
| meas_count | output | 32 | Completed periods |
| first_bin | output | 11 | Lowest occupied readout bin |
| last_bin | output | 11 | Highest occupied readout bin |
| not_empty | output | 1 | Readout page received an event |

## Verification
Counting on the working page can coincide with a host read of the readout page, and it can also run alongside a clear sweep of that readout page. The bench places an energy strobe in the same cycle as a read address. It checks that the read returns the readout-page value and that the counted event appears later on the other page. It also sends energies during a user clear and during an automatic sweep, and it checks that those events appear in the counts after the next swap while the swept page reads back as zeros.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [2:0] {
    PA_NONE,
    PA_SWAP,
    PA_SWEEP,
    PA_HOLD,
    PA_HALT
  } period_act_e;
endpackage

// File: rtl/hist_bin_map.sv
module hist_bin_map #(
  parameter int E_W  = 20,
  parameter int AW   = 11,
  parameter int SH_W = 4
) (
  input  logic [E_W-1:0]  energy,
  input  logic [E_W-1:0]  emin,
  input  logic [SH_W-1:0] shift,
  output logic [AW-1:0]   bin_idx
);
  localparam int HI_W = E_W - AW;

  logic [E_W-1:0]  diff;
  logic [E_W-1:0]  scaled;
  logic [HI_W-1:0] upper;

  always_comb begin
    diff   = energy - emin;
    scaled = diff >> shift;
    upper  = scaled[E_W-1:AW];
    if (energy < emin) begin
      bin_idx = '0;
    end else if (|upper) begin
      bin_idx = '1;
    end else begin
      bin_idx = scaled[AW-1:0];
    end
  end
endmodule

// File: rtl/hist_page_ram.sv
module hist_page_ram #(
  parameter int AW    = 11,
  parameter int DW    = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int AW  = 11,
  parameter int T_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sec_tick,
  input  logic [T_W-1:0] meas_time,
  input  logic           clr_mode,
  input  logic           hist_mode,
  input  logic           clr_cmd,
  output logic           sel,
  output logic           init_active,
  output logic           sweep_active,
  output logic [AW-1:0]  sweep_ptr,
  output logic           halted,
  output logic           cleared,
  output logic           swap_now,
  output logic           clear_fin,
  output logic [T_W-1:0] rec_time,
  output logic [T_W-1:0] meas_count
);
  localparam logic [AW-1:0] LAST = '1;

  logic           sel_q, sel_n;
  logic           init_q, init_n;
  logic           swp_q, swp_n;
  logic [AW-1:0]  ptr_q, ptr_n;
  logic           halt_q, halt_n;
  logic           pend_q, pend_n;
  logic           clean_q, clean_n;
  logic [T_W-1:0] rec_q, rec_n;
  logic [T_W-1:0] cnt_q, cnt_n;

  logic           period_end;
  logic           ptr_last;
  logic           init_fin;
  logic           sweep_fin;
  logic           clean_now;
  logic           start_user;
  period_act_e    act;

  always_comb begin
    period_end = sec_tick && ((T_W+1)'(rec_q) + (T_W+1)'(1) >= (T_W+1)'(meas_time));
    ptr_last   = (ptr_q == LAST);
    init_fin   = init_q && ptr_last;
    sweep_fin  = swp_q && ptr_last;
    clean_now  = clean_q || sweep_fin;

    if (!period_end || init_q || pend_q) begin
      act = PA_NONE;
    end else if (clean_now) begin
      act = PA_SWAP;
    end else if (!clr_mode) begin
      act = PA_SWEEP;
    end else if (swp_q) begin
      act = PA_HOLD;
    end else if (hist_mode) begin
      act = PA_HALT;
    end else begin
      act = PA_NONE;
    end

    start_user = clr_cmd && clr_mode && !swp_q && !init_q;
    swap_now   = (sweep_fin && pend_q) || (act == PA_SWAP);

    sel_n  = swap_now ? ~sel_q : sel_q;
    ptr_n  = (init_q || swp_q) ? ptr_q + 1'b1 : ptr_q;
    init_n = init_q && !ptr_last;
    swp_n  = swp_q ? !ptr_last : (start_user || (act == PA_SWEEP));

    if (swap_now) begin
      clean_n = 1'b0;
    end else if (init_fin || sweep_fin) begin
      clean_n = 1'b1;
    end else if (swp_n && !swp_q) begin
      clean_n = 1'b0;
    end else begin
      clean_n = clean_q;
    end

    if (swap_now) begin
      pend_n = 1'b0;
    end else if (act == PA_SWEEP || act == PA_HOLD || act == PA_HALT) begin
      pend_n = 1'b1;
    end else begin
      pend_n = pend_q;
    end

    if (swap_now) begin
      halt_n = 1'b0;
    end else if (act == PA_HALT) begin
      halt_n = 1'b1;
    end else begin
      halt_n = halt_q;
    end

    if (period_end) begin
      rec_n = '0;
      cnt_n = cnt_q + T_W'(1);
    end else if (sec_tick) begin
      rec_n = rec_q + T_W'(1);
      cnt_n = cnt_q;
    end else begin
      rec_n = rec_q;
      cnt_n = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      init_q  <= 1'b1;
      swp_q   <= 1'b0;
      ptr_q   <= '0;
      halt_q  <= 1'b0;
      pend_q  <= 1'b0;
      clean_q <= 1'b0;
      rec_q   <= '0;
      cnt_q   <= '0;
    end else begin
      sel_q   <= sel_n;
      init_q  <= init_n;
      swp_q   <= swp_n;
      ptr_q   <= ptr_n;
      halt_q  <= halt_n;
      pend_q  <= pend_n;
      clean_q <= clean_n;
      rec_q   <= rec_n;
      cnt_q   <= cnt_n;
    end
  end

  assign sel          = sel_q;
  assign init_active  = init_q;
  assign sweep_active = swp_q;
  assign sweep_ptr    = ptr_q;
  assign halted       = halt_q;
  assign cleared      = clean_q;
  assign clear_fin    = sweep_fin;
  assign rec_time     = rec_q;
  assign meas_count   = cnt_q;

  // R5
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (rec_q == '0) && (cnt_q == $past(cnt_q) + T_W'(1)));

  // R6
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swp_q && !ptr_last) |=> swp_q && (ptr_q == $past(ptr_q) + 1'b1));

  // R9
  halt_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> pend_q);

  // R8
  swap_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(clean_now));
endmodule

// File: rtl/energy_histogrammer.sv
module energy_histogrammer #(
  parameter int E_W   = 20,
  parameter int AW    = 11,
  parameter int CNT_W = 32,
  parameter int SH_W  = 4,
  parameter int T_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [E_W-1:0]   evt_energy,
  input  logic             sec_tick,
  input  logic [E_W-1:0]   cfg_emin,
  input  logic [SH_W-1:0]  cfg_shift,
  input  logic [T_W-1:0]   cfg_meas_time,
  input  logic             cfg_clr_mode,
  input  logic             cfg_hist_mode,
  input  logic             clr_cmd,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             page_sel,
  output logic             clr_done,
  output logic             halted,
  output logic [T_W-1:0]   rec_time,
  output logic [T_W-1:0]   meas_count,
  output logic [AW-1:0]    first_bin,
  output logic [AW-1:0]    last_bin,
  output logic             not_empty
);
  localparam int NPAGES = 2;

  logic             sel;
  logic             init_active;
  logic             sweep_active;
  logic [AW-1:0]    sweep_ptr;
  logic             halt_s;
  logic             cleared;
  logic             swap_now;
  logic             clear_fin;
  logic [AW-1:0]    bin_idx;
  logic             acc_en;

  logic [CNT_W-1:0] cnt_rd  [NPAGES];
  logic [CNT_W-1:0] host_rd [NPAGES];
  logic             pg_we   [NPAGES];
  logic [AW-1:0]    pg_addr [NPAGES];
  logic [CNT_W-1:0] pg_data [NPAGES];

  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] inc_cnt;

  logic [CNT_W-1:0] rd_q, rd_n;
  logic             wk_any_q, wk_any_n, wk_any_u;
  logic [AW-1:0]    wk_first_q, wk_first_n, wk_first_u;
  logic [AW-1:0]    wk_last_q, wk_last_n, wk_last_u;
  logic             ro_any_q, ro_any_n;
  logic [AW-1:0]    ro_first_q, ro_first_n;
  logic [AW-1:0]    ro_last_q, ro_last_n;

  hist_ctrl #(.AW(AW), .T_W(T_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .meas_time    (cfg_meas_time),
    .clr_mode     (cfg_clr_mode),
    .hist_mode    (cfg_hist_mode),
    .clr_cmd      (clr_cmd),
    .sel          (sel),
    .init_active  (init_active),
    .sweep_active (sweep_active),
    .sweep_ptr    (sweep_ptr),
    .halted       (halt_s),
    .cleared      (cleared),
    .swap_now     (swap_now),
    .clear_fin    (clear_fin),
    .rec_time     (rec_time),
    .meas_count   (meas_count)
  );

  hist_bin_map #(.E_W(E_W), .AW(AW), .SH_W(SH_W)) u_map (
    .energy  (evt_energy),
    .emin    (cfg_emin),
    .shift   (cfg_shift),
    .bin_idx (bin_idx)
  );

  assign acc_en  = evt_valid && !init_active && !halt_s;
  assign cur_cnt = cnt_rd[sel];
  assign inc_cnt = (&cur_cnt) ? cur_cnt : cur_cnt + CNT_W'(1);

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    always_comb begin
      if (init_active) begin
        pg_we[p]   = 1'b1;
        pg_addr[p] = sweep_ptr;
        pg_data[p] = '0;
      end else if (sel == 1'(p)) begin
        pg_we[p]   = acc_en;
        pg_addr[p] = bin_idx;
        pg_data[p] = inc_cnt;
      end else begin
        pg_we[p]   = sweep_active;
        pg_addr[p] = sweep_ptr;
        pg_data[p] = '0;
      end
    end

    hist_page_ram #(.AW(AW), .DW(CNT_W)) u_ram (
      .clk     (clk),
      .we      (pg_we[p]),
      .waddr   (pg_addr[p]),
      .wdata   (pg_data[p]),
      .raddr_a (bin_idx),
      .rdata_a (cnt_rd[p]),
      .raddr_b (rd_addr),
      .rdata_b (host_rd[p])
    );
  end

  always_comb begin
    rd_n = host_rd[~sel];

    if (acc_en) begin
      wk_any_u   = 1'b1;
      wk_first_u = (!wk_any_q || bin_idx < wk_first_q) ? bin_idx : wk_first_q;
      wk_last_u  = (!wk_any_q || bin_idx > wk_last_q)  ? bin_idx : wk_last_q;
    end else begin
      wk_any_u   = wk_any_q;
      wk_first_u = wk_first_q;
      wk_last_u  = wk_last_q;
    end

    if (swap_now) begin
      ro_any_n   = wk_any_u;
      ro_first_n = wk_first_u;
      ro_last_n  = wk_last_u;
      wk_any_n   = 1'b0;
      wk_first_n = '0;
      wk_last_n  = '0;
    end else if (clear_fin) begin
      ro_any_n   = 1'b0;
      ro_first_n = '0;
      ro_last_n  = '0;
      wk_any_n   = wk_any_u;
      wk_first_n = wk_first_u;
      wk_last_n  = wk_last_u;
    end else begin
      ro_any_n   = ro_any_q;
      ro_first_n = ro_first_q;
      ro_last_n  = ro_last_q;
      wk_any_n   = wk_any_u;
      wk_first_n = wk_first_u;
      wk_last_n  = wk_last_u;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= '0;
      wk_any_q   <= 1'b0;
      wk_first_q <= '0;
      wk_last_q  <= '0;
      ro_any_q   <= 1'b0;
      ro_first_q <= '0;
      ro_last_q  <= '0;
    end else begin
      rd_q       <= rd_n;
      wk_any_q   <= wk_any_n;
      wk_first_q <= wk_first_n;
      wk_last_q  <= wk_last_n;
      ro_any_q   <= ro_any_n;
      ro_first_q <= ro_first_n;
      ro_last_q  <= ro_last_n;
    end
  end

  assign rd_data   = rd_q;
  assign page_sel  = sel;
  assign clr_done  = cleared;
  assign halted    = halt_s;
  assign first_bin = ro_first_q;
  assign last_bin  = ro_last_q;
  assign not_empty = ro_any_q;

  // R3
  sat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> (inc_cnt >= cur_cnt) && (inc_cnt != '0));

  // R10
  bin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_any_q |-> (ro_first_q <= ro_last_q));

  // R12
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |=> $stable(sel) && !halt_s);
endmodule

// File: tb/test_energy_histogrammer.sv
module test_energy_histogrammer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [19:0] evt_energy;
  logic        sec_tick;
  logic [19:0] cfg_emin;
  logic [3:0]  cfg_shift;
  logic [31:0] cfg_meas_time;
  logic        cfg_clr_mode;
  logic        cfg_hist_mode;
  logic        clr_cmd;
  logic [10:0] rd_addr;
  logic [31:0] rd_data;
  logic        page_sel, clr_done, halted, not_empty;
  logic [31:0] rec_time, meas_count;
  logic [10:0] first_bin, last_bin;

  logic        s_valid, s_tick;
  logic [19:0] s_energy;
  logic [10:0] s_addr;
  logic [2:0]  s_data;
  logic        s_sel, s_done, s_halt, s_ne;
  logic [31:0] s_rec, s_cnt;
  logic [10:0] s_first, s_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  energy_histogrammer i_energy_histogrammer (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_energy(evt_energy),
    .sec_tick(sec_tick), .cfg_emin(cfg_emin), .cfg_shift(cfg_shift),
    .cfg_meas_time(cfg_meas_time), .cfg_clr_mode(cfg_clr_mode),
    .cfg_hist_mode(cfg_hist_mode), .clr_cmd(clr_cmd), .rd_addr(rd_addr),
    .rd_data(rd_data), .page_sel(page_sel), .clr_done(clr_done), .halted(halted),
    .rec_time(rec_time), .meas_count(meas_count), .first_bin(first_bin),
    .last_bin(last_bin), .not_empty(not_empty)
  );

  energy_histogrammer #(.CNT_W(3)) i_sat (
    .clk(clk), .rst_n(rst_n), .evt_valid(s_valid), .evt_energy(s_energy),
    .sec_tick(s_tick), .cfg_emin(cfg_emin), .cfg_shift(cfg_shift),
    .cfg_meas_time(cfg_meas_time), .cfg_clr_mode(cfg_clr_mode),
    .cfg_hist_mode(cfg_hist_mode), .clr_cmd(1'b0), .rd_addr(s_addr),
    .rd_data(s_data), .page_sel(s_sel), .clr_done(s_done), .halted(s_halt),
    .rec_time(s_rec), .meas_count(s_cnt), .first_bin(s_first),
    .last_bin(s_last), .not_empty(s_ne)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic send(input logic [19:0] e);
    @(negedge clk); evt_valid = 1'b1; evt_energy = e;
    @(negedge clk); evt_valid = 1'b0;
  endtask

  task automatic clear_pulse();
    @(negedge clk); clr_cmd = 1'b1;
    @(negedge clk); clr_cmd = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic t_reset();
    chk("R4 page_sel after reset", page_sel, 0);
    chk("R5 rec_time after reset", rec_time, 0);
    chk("R5 meas_count after reset", meas_count, 0);
    chk("R10 not_empty after reset", not_empty, 0);
    chk("R12 clr_done low during init", clr_done, 0);
    send(20'd1200);
    idle(2100);
    chk("R12 clr_done after init", clr_done, 1);
    chk("R9 halted idle", halted, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); s_valid = 1'b1; s_energy = 20'd0;
    end
    @(negedge clk); s_valid = 1'b0; s_tick = 1'b1;
    @(negedge clk); s_tick = 1'b0; s_addr = 11'd0;
    @(negedge clk);
    chk("R3 saturated bin", s_data, 7);
  endtask

  task automatic t_binning();
    logic [31:0] v;
    send(20'd1000); send(20'd1013); send(20'd1015); send(20'd500);
    send(20'd9192); send(20'd9188); send(20'hFFFFF);
    tick();
    chk("R8 swap when clean", page_sel, 1);
    chk("R5 meas_count after first period", meas_count, 1);
    rd(11'd0, v);    chk("R2 below range to bin 0", v, 2);
    rd(11'd3, v);    chk("R1 offset and shift bin 3", v, 2);
    rd(11'd1, v);    chk("R1 untouched bin 1", v, 0);
    rd(11'd2047, v); chk("R2 above range to bin 2047", v, 3);
    chk("R10 first_bin", first_bin, 0);
    chk("R10 last_bin", last_bin, 2047);
    chk("R10 not_empty", not_empty, 1);
    chk("R12 event during init dropped (bin 50)", 0, 0);
    rd(11'd50, v);   chk("R12 bin 50 empty", v, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); evt_valid = 1'b1; evt_energy = 20'd1004; rd_addr = 11'd3;
    @(negedge clk); evt_valid = 1'b0;
    chk("R11 read beside event", rd_data, 2);
  endtask

  task automatic t_no_clear_continue();
    tick();
    chk("R8 no swap while unclear", page_sel, 1);
    chk("R5 meas_count two", meas_count, 2);
    send(20'd1004);
  endtask

  task automatic t_user_clear();
    logic [31:0] v;
    clear_pulse();
    idle(5);
    send(20'd1004);
    idle(2100);
    chk("R7 clr_done after sweep", clr_done, 1);
    chk("R7 not_empty after sweep", not_empty, 0);
    rd(11'd0, v);    chk("R7 bin 0 zeroed", v, 0);
    rd(11'd2047, v); chk("R7 bin 2047 zeroed", v, 0);
    tick();
    chk("R8 swap after user clear", page_sel, 0);
    chk("R7 clr_done dropped by swap", clr_done, 0);
    rd(11'd1, v);    chk("R11 counts kept beside read and sweep", v, 3);
    chk("R10 first_bin single", first_bin, 1);
    chk("R10 last_bin single", last_bin, 1);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    cfg_hist_mode = 1'b1;
    tick();
    chk("R9 halted raised", halted, 1);
    chk("R9 no swap on halt", page_sel, 0);
    send(20'd1020);
    clear_pulse();
    idle(2100);
    chk("R9 swap after clear", page_sel, 1);
    chk("R9 halted released", halted, 0);
    chk("R9 dropped event leaves page empty", not_empty, 0);
    rd(11'd5, v);    chk("R9 bin 5 empty", v, 0);
    cfg_hist_mode = 1'b0;
  endtask

  task automatic t_auto_clear();
    logic [31:0] v;
    cfg_clr_mode = 1'b0;
    send(20'd1028);
    tick();
    idle(20);
    chk("R6 swap deferred during sweep", page_sel, 1);
    send(20'd1028);
    idle(2100);
    chk("R6 swap after sweep", page_sel, 0);
    rd(11'd7, v);    chk("R6 events during sweep kept", v, 2);
    chk("R10 first_bin auto", first_bin, 7);
    chk("R10 last_bin auto", last_bin, 7);
    clear_pulse();
    idle(2100);
    chk("R7 clr_cmd ignored in auto mode", clr_done, 0);
    rd(11'd7, v);    chk("R7 readout intact", v, 2);
  endtask

  task automatic t_period_len();
    cfg_clr_mode  = 1'b1;
    cfg_meas_time = 32'd3;
    tick(); chk("R5 rec_time 1", rec_time, 1);
    tick(); chk("R5 rec_time 2", rec_time, 2);
    chk("R5 meas_count held", meas_count, 5);
    tick(); chk("R5 rec_time wrap", rec_time, 0);
    chk("R5 meas_count step", meas_count, 6);
    chk("R8 page kept without clear", page_sel, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_energy = '0; sec_tick = 1'b0;
    cfg_emin = 20'd1000; cfg_shift = 4'd2; cfg_meas_time = 32'd1;
    cfg_clr_mode = 1'b1; cfg_hist_mode = 1'b0; clr_cmd = 1'b0; rd_addr = '0;
    s_valid = 1'b0; s_tick = 1'b0; s_energy = '0; s_addr = '0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_saturate();
    t_binning();
    t_same_cycle();
    t_no_clear_continue();
    t_user_clear();
    t_halt();
    t_auto_clear();
    t_period_len();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule